// File: doc/BRIEF.md
# Flash Read Path with Write Status and Identification Codes

This block forms the byte a flash-style memory returns to the host on every read. In normal operation it passes array data through. While an internal erase/program cycle is running, it returns a status byte instead. That byte carries an inverted copy of the top bit of the last byte the host loaded, plus a bit that alternates from one status read to the next. In identification mode it decodes the address and returns the maker code, the device code and the lock state of the low and high boot sectors.

A read is open while both active-low selects are low. Everything is sampled on the clock and the byte and its drive qualifier come out of registers, one cycle after the inputs. The pad logic uses the qualifier to release the bus to high impedance. The surrounding memory supplies the busy flag, the mode and lock flags, the array byte for the presented address, and a strobe with the top bit of each byte loaded into the page buffer.

Top module: `rdp_read_path`

## Requirements
- R1: One cycle after both `chip_sel_n` and `out_en_n` are sampled low, `rd_drive` is 1. In any other cycle, one cycle later `rd_drive` is 0 and `rd_data` is 00h.
- R2: While `busy` is 1, bit 7 of a read returns the inverse of the `ld_msb` value captured by the most recent `ld_valid` pulse.
- R3: Once `busy` returns to 0, a read gives the true array byte again, not the status byte.
- R4: While `busy` is 1, bit 6 of successive reads alternates 0, 1, 0, ... and the first read after `busy` rises returns 0. The bit advances only when a status read closes, and it holds steady for the whole length of one read.
- R5: While `busy` is 1, bits 5 to 0 of a read are 0.
- R6: With `id_mode` at 1 and `busy` at 0, address 0 reads DAh and address 1 reads 45h.
- R7: With `id_mode` at 1 and `busy` at 0, address 2 reads FFh if `lock_lo` is 1 and FEh if it is 0. The address with all bits 1 except bits 3, 2 and 0 (3FFF2h for an 18-bit address) reads the same way from `lock_hi`.
- R8: In identification mode, any other address reads 00h. `busy` takes priority over `id_mode`.
- R9: With `busy` and `id_mode` both 0, a read returns the `arr_data` value sampled in the same cycle as the selects.
- R10: After reset, `rd_drive` is 0 and `rd_data` is 00h, and the stored load bit is 0, so the first status read returns 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Device select, active low |
| out_en_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Read address |
| busy | input | 1 | Internal write cycle running |
| id_mode | input | 1 | Identification mode active |
| lock_lo | input | 1 | Low boot sector is locked |
| lock_hi | input | 1 | High boot sector is locked |
| arr_data | input | DATA_W | Array byte at `addr` |
| ld_valid | input | 1 | A byte is being loaded into the page buffer |
| ld_msb | input | 1 | Top bit of the byte being loaded |
| rd_data | output | DATA_W | Registered read byte |
| rd_drive | output | 1 | Registered drive qualifier; 0 means high impedance |

## Verification
The bench builds the block with a 12-bit address and the default 8-bit data and default codes. This moves the high lock address to FF2h, so the bench checks that this address is derived from the width and not fixed. The short address keeps the array stub cheap. The bench drives status reads back to back and also holds one read open over several cycles. This separates the rule that the toggle advances when a read closes from a toggle that would advance every clock. It also lets `busy` drop and rise again, to show the toggle restarting at 0.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_ARRAY  = 2'd1,
    SRC_STATUS = 2'd2,
    SRC_IDENT  = 2'd3
  } rd_src_e;

  localparam logic [7:0] DEF_MFG_CODE = 8'hDA;
  localparam logic [7:0] DEF_DEV_CODE = 8'h45;

endpackage

// File: rtl/rdp_status_track.sv
module rdp_status_track (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rd_act,
  input  logic ld_valid,
  input  logic ld_msb,
  output logic poll_bit,
  output logic tgl_bit
);

  logic last_msb_q;
  logic tgl_q;
  logic seen_q;

  // Capture the load bit; advance the toggle when a status read closes.
  always_ff @(posedge clk) begin
    if (rst) begin
      last_msb_q <= 1'b0;
      tgl_q      <= 1'b0;
      seen_q     <= 1'b0;
    end else begin
      if (ld_valid) begin
        last_msb_q <= ld_msb;
      end
      if (!busy) begin
        tgl_q  <= 1'b0;
        seen_q <= 1'b0;
      end else if (rd_act) begin
        seen_q <= 1'b1;
      end else if (seen_q) begin
        tgl_q  <= ~tgl_q;
        seen_q <= 1'b0;
      end
    end
  end

  assign poll_bit = ~last_msb_q;
  assign tgl_bit  = tgl_q;

endmodule

// File: rtl/rdp_id_rom.sv
module rdp_id_rom #(
  parameter int unsigned      ADDR_W   = 18,
  parameter int unsigned      DATA_W   = 8,
  parameter logic [DATA_W-1:0] MFG_CODE = rdp_pkg::DEF_MFG_CODE,
  parameter logic [DATA_W-1:0] DEV_CODE = rdp_pkg::DEF_DEV_CODE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock_lo,
  input  logic              lock_hi,
  output logic [DATA_W-1:0] id_data
);

  localparam logic [ADDR_W-1:0] A_MFG     = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DEV     = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_LOCK_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_LOCK_HI = ~ADDR_W'(13);
  localparam logic [DATA_W-1:0] C_LOCKED  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] C_OPEN    = {{(DATA_W-1){1'b1}}, 1'b0};

  always_comb begin
    id_data = '0;
    if (addr == A_MFG) begin
      id_data = MFG_CODE;
    end else if (addr == A_DEV) begin
      id_data = DEV_CODE;
    end else if (addr == A_LOCK_LO) begin
      id_data = lock_lo ? C_LOCKED : C_OPEN;
    end else if (addr == A_LOCK_HI) begin
      id_data = lock_hi ? C_LOCKED : C_OPEN;
    end
  end

endmodule

// File: rtl/rdp_read_path.sv
module rdp_read_path #(
  parameter int unsigned      ADDR_W   = 18,
  parameter int unsigned      DATA_W   = 8,
  parameter logic [DATA_W-1:0] MFG_CODE = rdp_pkg::DEF_MFG_CODE,
  parameter logic [DATA_W-1:0] DEV_CODE = rdp_pkg::DEF_DEV_CODE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy,
  input  logic              id_mode,
  input  logic              lock_lo,
  input  logic              lock_hi,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              ld_valid,
  input  logic              ld_msb,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_drive
);

  import rdp_pkg::*;

  localparam int unsigned POLL_BIT = DATA_W - 1;
  localparam int unsigned TGL_BIT  = DATA_W - 2;

  logic              rd_act;
  logic              poll_bit;
  logic              tgl_bit;
  logic [DATA_W-1:0] id_data;
  logic [DATA_W-1:0] stat_data;
  logic [DATA_W-1:0] nxt_data;
  rd_src_e           src;

  assign rd_act = !chip_sel_n && !out_en_n;

  rdp_status_track u_track (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .rd_act   (rd_act),
    .ld_valid (ld_valid),
    .ld_msb   (ld_msb),
    .poll_bit (poll_bit),
    .tgl_bit  (tgl_bit)
  );

  rdp_id_rom #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .MFG_CODE (MFG_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_id (
    .addr    (addr),
    .lock_lo (lock_lo),
    .lock_hi (lock_hi),
    .id_data (id_data)
  );

  always_comb begin
    stat_data           = '0;
    stat_data[POLL_BIT] = poll_bit;
    stat_data[TGL_BIT]  = tgl_bit;
  end

  always_comb begin
    if (!rd_act)      src = SRC_NONE;
    else if (busy)    src = SRC_STATUS;
    else if (id_mode) src = SRC_IDENT;
    else              src = SRC_ARRAY;
  end

  always_comb begin
    unique case (src)
      SRC_STATUS: nxt_data = stat_data;
      SRC_IDENT:  nxt_data = id_data;
      SRC_ARRAY:  nxt_data = arr_data;
      default:    nxt_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_drive <= 1'b0;
    end else begin
      rd_data  <= nxt_data;
      rd_drive <= rd_act;
    end
  end

endmodule

// File: rtl/rdp_read_path_chk.sv
module rdp_read_path_chk #(
  parameter int unsigned      ADDR_W   = 18,
  parameter int unsigned      DATA_W   = 8,
  parameter logic [DATA_W-1:0] MFG_CODE = 8'hDA,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h45
) (
  input logic              clk,
  input logic              rst,
  input logic              chip_sel_n,
  input logic              out_en_n,
  input logic [ADDR_W-1:0] addr,
  input logic              busy,
  input logic              id_mode,
  input logic              lock_lo,
  input logic [DATA_W-1:0] arr_data,
  input logic              ld_valid,
  input logic              ld_msb,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_drive
);

  logic act;
  logic sh_msb;

  assign act = !chip_sel_n && !out_en_n;

  always_ff @(posedge clk) begin
    if (rst)           sh_msb <= 1'b0;
    else if (ld_valid) sh_msb <= ld_msb;
  end

  p_drive_r1: assert property (@(posedge clk) disable iff (rst)
    act |=> rd_drive);

  p_hiz_r1: assert property (@(posedge clk) disable iff (rst)
    !act |=> (!rd_drive && rd_data == '0));

  p_poll_r2: assert property (@(posedge clk) disable iff (rst)
    (act && busy) |=> (rd_data[DATA_W-1] == ~$past(sh_msb)));

  p_tgl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (act && busy && $past(act) && $past(busy)) |=> $stable(rd_data[DATA_W-2]));

  p_stat_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (act && busy) |=> (rd_data[DATA_W-3:0] == '0));

  p_id_mfg_r6: assert property (@(posedge clk) disable iff (rst)
    (act && !busy && id_mode && addr == ADDR_W'(0)) |=> (rd_data == MFG_CODE));

  p_id_dev_r6: assert property (@(posedge clk) disable iff (rst)
    (act && !busy && id_mode && addr == ADDR_W'(1)) |=> (rd_data == DEV_CODE));

  p_lock_lo_r7: assert property (@(posedge clk) disable iff (rst)
    (act && !busy && id_mode && addr == ADDR_W'(2)) |=>
      (rd_data == ($past(lock_lo) ? {DATA_W{1'b1}} : {{(DATA_W-1){1'b1}}, 1'b0})));

  p_array_r9: assert property (@(posedge clk) disable iff (rst)
    (act && !busy && !id_mode) |=> (rd_data == $past(arr_data)));

endmodule

bind rdp_read_path rdp_read_path_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .MFG_CODE (MFG_CODE),
  .DEV_CODE (DEV_CODE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .chip_sel_n (chip_sel_n),
  .out_en_n   (out_en_n),
  .addr       (addr),
  .busy       (busy),
  .id_mode    (id_mode),
  .lock_lo    (lock_lo),
  .arr_data   (arr_data),
  .ld_valid   (ld_valid),
  .ld_msb     (ld_msb),
  .rd_data    (rd_data),
  .rd_drive   (rd_drive)
);

// File: tb/tb_rdp_read_path.sv
`timescale 1ns/1ps
module tb_rdp_read_path;

  localparam int unsigned AW = 12;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          chip_sel_n = 1'b1;
  logic          out_en_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          busy = 1'b0;
  logic          id_mode = 1'b0;
  logic          lock_lo = 1'b0;
  logic          lock_hi = 1'b0;
  logic [DW-1:0] arr_data;
  logic          ld_valid = 1'b0;
  logic          ld_msb = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_drive;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  assign arr_data = addr[7:0] ^ 8'h5A;

  rdp_read_path #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .out_en_n(out_en_n),
    .addr(addr), .busy(busy), .id_mode(id_mode), .lock_lo(lock_lo),
    .lock_hi(lock_hi), .arr_data(arr_data), .ld_valid(ld_valid),
    .ld_msb(ld_msb), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // One-cycle read; the result is sampled at the following falling edge.
  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic drv);
    @(negedge clk);
    chip_sel_n = 1'b0; out_en_n = 1'b0; addr = a;
    @(negedge clk);
    d = rd_data; drv = rd_drive;
    chip_sel_n = 1'b1; out_en_n = 1'b1;
  endtask

  task automatic load(input logic msb);
    @(negedge clk);
    ld_valid = 1'b1; ld_msb = msb;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d; logic drv;
    chk("R10 reset data", rd_data, 8'h00);
    chk("R10 reset drive", {7'b0, rd_drive}, 8'h00);
    busy = 1'b1;
    rd(12'h010, d, drv);
    chk("R10 first status read", d, 8'h80);
    @(negedge clk); busy = 1'b0;
  endtask

  task automatic t_hiz();
    @(negedge clk); chip_sel_n = 1'b0; out_en_n = 1'b1; addr = 12'h033;
    @(negedge clk);
    chk("R1 oe high drive", {7'b0, rd_drive}, 8'h00);
    chk("R1 oe high data", rd_data, 8'h00);
    chip_sel_n = 1'b1; out_en_n = 1'b0;
    @(negedge clk);
    chk("R1 ce high drive", {7'b0, rd_drive}, 8'h00);
    chk("R1 ce high data", rd_data, 8'h00);
    out_en_n = 1'b1;
  endtask

  task automatic t_array();
    logic [DW-1:0] d; logic drv;
    rd(12'h000, d, drv);
    chk("R9 array 000", d, 8'h5A);
    chk("R1 drive during read", {7'b0, drv}, 8'h01);
    rd(12'hAC3, d, drv);
    chk("R9 array AC3", d, 8'hC3 ^ 8'h5A);
    rd(12'hFFF, d, drv);
    chk("R9 array FFF", d, 8'hFF ^ 8'h5A);
  endtask

  task automatic t_ident();
    logic [DW-1:0] d; logic drv;
    @(negedge clk); id_mode = 1'b1; lock_lo = 1'b1; lock_hi = 1'b0;
    rd(12'h000, d, drv); chk("R6 maker code", d, 8'hDA);
    rd(12'h001, d, drv); chk("R6 device code", d, 8'h45);
    rd(12'h002, d, drv); chk("R7 low locked", d, 8'hFF);
    rd(12'hFF2, d, drv); chk("R7 high open", d, 8'hFE);
    @(negedge clk); lock_lo = 1'b0; lock_hi = 1'b1;
    rd(12'h002, d, drv); chk("R7 low open", d, 8'hFE);
    rd(12'hFF2, d, drv); chk("R7 high locked", d, 8'hFF);
    rd(12'h003, d, drv); chk("R8 other id addr 003", d, 8'h00);
    rd(12'h100, d, drv); chk("R8 other id addr 100", d, 8'h00);
    @(negedge clk); id_mode = 1'b0;
  endtask

  task automatic t_status();
    logic [DW-1:0] d; logic drv; logic [DW-1:0] d2;
    load(1'b0);
    load(1'b1);
    @(negedge clk); busy = 1'b1;
    rd(12'h044, d, drv); chk("R2 R4 R5 status read 0", d, 8'h00);
    rd(12'h044, d, drv); chk("R4 status read 1", d, 8'h40);
    rd(12'h044, d, drv); chk("R4 status read 2", d, 8'h00);
    // Long read: bit 6 must hold while the read stays open.
    @(negedge clk); chip_sel_n = 1'b0; out_en_n = 1'b0;
    @(negedge clk); d = rd_data;
    @(negedge clk); d2 = rd_data;
    @(negedge clk); chip_sel_n = 1'b1; out_en_n = 1'b1;
    chk("R4 long read first", d, 8'h40);
    chk("R4 long read held", d2, 8'h40);
    rd(12'h044, d, drv); chk("R4 after long read", d, 8'h00);
    @(negedge clk); id_mode = 1'b1;
    rd(12'h000, d, drv); chk("R8 busy over id", d, 8'h40);
    @(negedge clk); id_mode = 1'b0; busy = 1'b0;
    rd(12'h044, d, drv); chk("R3 true data after busy", d, 8'h44 ^ 8'h5A);
    load(1'b0);
    @(negedge clk); busy = 1'b1;
    rd(12'h044, d, drv); chk("R2 R4 restart after busy", d, 8'h80);
    rd(12'h044, d, drv); chk("R4 restart second", d, 8'hC0);
    @(negedge clk); busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hiz();
    t_array();
    t_ident();
    t_status();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule